// File: doc/BRIEF.md
# Display Window Write Sequencer (4-wire serial with data/command pin)

This block sends a rectangle of pixels, or a plain command, to a display controller over a write-only serial link. The link has a clock, a data line, an active-low select and a separate data/command (D/C) pin. After a one-cycle `start` the block latches the window corners, the mode and the command length. It then emits the addressing command bytes for the chosen mode and streams pixel bytes taken from a valid/ready input. It raises select when the last bit has left the shifter.

Four modes share one byte path. Windowed mode sets a row range and a column range, then opens RAM writing and streams two bytes per column for every row. Page mode repeats a three-byte page/column setup in front of each page. Horizontal mode sends one command burst that selects horizontal addressing and both ranges, then streams every page back to back. Command mode forwards `cmd_len`+1 bytes from the stream. The first of these is a command; the rest are parameters whose D/C level depends on `late_dc`. All command codes are parameters.

Stream rules: a byte is transferred on a rising clock edge where `s_valid` and `s_ready` are both high. `s_ready` is high only during a data phase, and only while the shifter is idle. When `s_valid` is low the serial clock holds low and nothing is lost or repeated. A producer may hold `s_valid` high for as long as it likes.

Top module: `dws_window_seq`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sclk` is 0, `busy` is 0 and `s_ready` is 0.
- R2: Bytes go out MSB first with the clock idle low. Each bit is held CLK_HALF cycles with the clock low, then CLK_HALF cycles high. The receiver samples on the rising edge. `spi_cs_n` is 0 whenever a bit is being shifted.
- R3: Windowed mode (`mode`=0) sends, in order: ROW_OP with D/C=0, start row and end row with D/C=1, COL_OP with D/C=0, start column and end column with D/C=1, then RAM_OP with D/C=0.
- R4: In windowed mode, (end row − start row + 1) × (end column − start column + 1) × 2 stream bytes follow with D/C=1, in stream order.
- R5: Page mode (`mode`=1) handles each page from start row to end row in turn. For each page it sends PAGE_BASE+page, COLH_BASE+col_start[7:4] and COLL_BASE+col_start[3:0], all with D/C=0, then (end column − start column + 1) stream bytes with D/C=1.
- R6: Horizontal mode (`mode`=2) sends AMODE_OP, AMODE_HORIZ, CRANGE_OP, start column, end column, PRANGE_OP, start row and end row, all with D/C=0. After that it sends pages × columns stream bytes with D/C=1.
- R7: Command mode (`mode`=3) sends `cmd_len`+1 stream bytes. The first has D/C=0. The others have D/C=0 when `late_dc`=1 and D/C=1 otherwise.
- R8: D/C never changes while a byte is being shifted.
- R9: While `s_valid` is low in a data phase, no byte is shifted. Every accepted byte appears exactly once on the wire. `s_ready` is never high outside a data phase.
- R10: A `start` pulse while `busy`=1 is ignored. So are changes to the window, mode and length inputs; the running transfer continues unchanged.
- R11: `busy` falls and `spi_cs_n` rises only after the last bit of the last byte, and no partial byte is left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (ignored while busy) |
| mode | input | 2 | 0 window, 1 page, 2 horizontal, 3 command |
| late_dc | input | 1 | Keep D/C low for command parameters |
| col_start | input | 8 | First column |
| col_end | input | 8 | Last column (≥ col_start) |
| row_start | input | 8 | First row or page |
| row_end | input | 8 | Last row or page (≥ row_start) |
| cmd_len | input | CMD_LEN_W | Command mode byte count minus one |
| s_valid | input | 1 | Stream byte available |
| s_data | input | 8 | Stream byte |
| s_ready | output | 1 | Stream byte taken this cycle |
| busy | output | 1 | Transfer in progress |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data |
| spi_cs_n | output | 1 | Select, active low |
| spi_dc | output | 1 | 0 command, 1 data |

## Verification
The bench builds the block with CLK_HALF=1, so a byte costs seventeen cycles and more than a hundred windows fit in the run. It sweeps column starts 0, 44 and 167, which give distinct high and low nibbles for the page-mode split. It also sweeps widths of one to three columns, row starts 0 and 5, and one to three rows or pages in each of the three addressing modes. Command mode is swept over every length up to five bytes with both D/C options. The stream input is throttled with regular gaps, so stalls in the middle of a row are always exercised. One run injects a second start with altered inputs while a transfer is in progress.

// File: rtl/dws_pkg.sv
`timescale 1ns/1ps
package dws_pkg;
  typedef enum logic [1:0] {
    MODE_WINDOW = 2'd0,
    MODE_PAGE   = 2'd1,
    MODE_HORIZ  = 2'd2,
    MODE_CMD    = 2'd3
  } dws_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DAT  = 2'd2,
    ST_FIN  = 2'd3
  } dws_state_e;
endpackage

// File: rtl/dws_bit_tx.sv
`timescale 1ns/1ps
module dws_bit_tx #(
  parameter int CLK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  input  logic       in_dc,
  output logic       in_ready,
  output logic       sclk,
  output logic       mosi,
  output logic       dc
);
  localparam int DW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam logic [DW-1:0] DLAST = DW'(CLK_HALF - 1);

  logic          active;
  logic          sclk_q;
  logic          dc_q;
  logic [7:0]    shreg;
  logic [2:0]    bitn;
  logic [DW-1:0] dcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sclk_q <= 1'b0;
      dc_q   <= 1'b0;
      shreg  <= 8'h00;
      bitn   <= 3'd0;
      dcnt   <= '0;
    end else if (!active) begin
      if (in_valid) begin
        active <= 1'b1;
        shreg  <= in_byte;
        dc_q   <= in_dc;
        bitn   <= 3'd0;
        dcnt   <= '0;
        sclk_q <= 1'b0;
      end
    end else if (dcnt != DLAST) begin
      dcnt <= dcnt + 1'b1;
    end else begin
      dcnt <= '0;
      if (!sclk_q) begin
        sclk_q <= 1'b1;
      end else begin
        sclk_q <= 1'b0;
        if (bitn == 3'd7) begin
          active <= 1'b0;
        end else begin
          bitn  <= bitn + 3'd1;
          shreg <= {shreg[6:0], 1'b0};
        end
      end
    end
  end

  assign in_ready = !active;
  assign sclk     = sclk_q;
  assign mosi     = shreg[7];
  assign dc       = dc_q;

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sclk_q); // R2
  AST_DC_HELD_IN_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(dc_q)); // R8
endmodule

// File: rtl/dws_ctrl.sv
`timescale 1ns/1ps
module dws_ctrl
  import dws_pkg::*;
#(
  parameter int         CMD_LEN_W   = 4,
  parameter logic [7:0] ROW_OP      = 8'h75,
  parameter logic [7:0] COL_OP      = 8'h15,
  parameter logic [7:0] RAM_OP      = 8'h5C,
  parameter logic [7:0] PAGE_BASE   = 8'hB0,
  parameter logic [7:0] COLH_BASE   = 8'h10,
  parameter logic [7:0] COLL_BASE   = 8'h00,
  parameter logic [7:0] AMODE_OP    = 8'h20,
  parameter logic [7:0] AMODE_HORIZ = 8'h00,
  parameter logic [7:0] CRANGE_OP   = 8'h21,
  parameter logic [7:0] PRANGE_OP   = 8'h22
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           mode_i,
  input  logic                 late_i,
  input  logic [7:0]           col_s,
  input  logic [7:0]           col_e,
  input  logic [7:0]           row_s,
  input  logic [7:0]           row_e,
  input  logic [CMD_LEN_W-1:0] cmd_len,
  input  logic                 s_valid,
  input  logic [7:0]           s_data,
  output logic                 s_ready,
  input  logic                 tx_ready,
  output logic                 tx_valid,
  output logic [7:0]           tx_byte,
  output logic                 tx_dc,
  output logic                 busy,
  output logic                 cs_n
);
  localparam int BW = 9;

  dws_state_e           st;
  dws_mode_e            mode_q;
  logic                 late_q;
  logic [7:0]           cs_q, ce_q, rs_q, re_q, cur;
  logic [CMD_LEN_W-1:0] len_q;
  logic [3:0]           hidx, hlast;
  logic [BW-1:0]        bcnt, row_m1;
  logic [7:0]           span, hbyte;
  logic                 hdc, acc;

  assign span = ce_q - cs_q;

  always_comb begin
    hbyte  = 8'h00;
    hdc    = 1'b0;
    hlast  = 4'd0;
    row_m1 = {1'b0, span};
    case (mode_q)
      MODE_WINDOW: begin
        hlast  = 4'd6;
        row_m1 = {span, 1'b1};
        case (hidx)
          4'd0:    hbyte = ROW_OP;
          4'd1:    begin hbyte = rs_q; hdc = 1'b1; end
          4'd2:    begin hbyte = re_q; hdc = 1'b1; end
          4'd3:    hbyte = COL_OP;
          4'd4:    begin hbyte = cs_q; hdc = 1'b1; end
          4'd5:    begin hbyte = ce_q; hdc = 1'b1; end
          default: hbyte = RAM_OP;
        endcase
      end
      MODE_PAGE: begin
        hlast = 4'd2;
        case (hidx)
          4'd0:    hbyte = PAGE_BASE + cur;
          4'd1:    hbyte = COLH_BASE + {4'h0, cs_q[7:4]};
          default: hbyte = COLL_BASE + {4'h0, cs_q[3:0]};
        endcase
      end
      MODE_HORIZ: begin
        hlast = 4'd7;
        case (hidx)
          4'd0:    hbyte = AMODE_OP;
          4'd1:    hbyte = AMODE_HORIZ;
          4'd2:    hbyte = CRANGE_OP;
          4'd3:    hbyte = cs_q;
          4'd4:    hbyte = ce_q;
          4'd5:    hbyte = PRANGE_OP;
          4'd6:    hbyte = rs_q;
          default: hbyte = re_q;
        endcase
      end
      default: begin
        row_m1 = BW'(len_q);
      end
    endcase
  end

  always_comb begin
    if (st == ST_HDR) begin
      tx_valid = 1'b1;
      tx_byte  = hbyte;
      tx_dc    = hdc;
    end else begin
      tx_valid = (st == ST_DAT) && s_valid;
      tx_byte  = s_data;
      if (mode_q == MODE_CMD) tx_dc = (bcnt != '0) && !late_q;
      else                    tx_dc = 1'b1;
    end
  end

  assign s_ready = (st == ST_DAT) && tx_ready;
  assign acc     = tx_valid && tx_ready;
  assign busy    = (st != ST_IDLE);
  assign cs_n    = (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      mode_q <= MODE_WINDOW;
      late_q <= 1'b0;
      cs_q   <= 8'h00;
      ce_q   <= 8'h00;
      rs_q   <= 8'h00;
      re_q   <= 8'h00;
      len_q  <= '0;
      cur    <= 8'h00;
      hidx   <= 4'd0;
      bcnt   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          mode_q <= dws_mode_e'(mode_i);
          late_q <= late_i;
          cs_q   <= col_s;
          ce_q   <= col_e;
          rs_q   <= row_s;
          re_q   <= row_e;
          len_q  <= cmd_len;
          cur    <= row_s;
          hidx   <= 4'd0;
          bcnt   <= '0;
          st     <= (dws_mode_e'(mode_i) == MODE_CMD) ? ST_DAT : ST_HDR;
        end
        ST_HDR: if (acc) begin
          if (hidx == hlast) begin
            hidx <= 4'd0;
            bcnt <= '0;
            st   <= ST_DAT;
          end else begin
            hidx <= hidx + 4'd1;
          end
        end
        ST_DAT: if (acc) begin
          if (bcnt == row_m1) begin
            bcnt <= '0;
            if (mode_q == MODE_CMD || cur == re_q) begin
              st <= ST_FIN;
            end else begin
              cur <= cur + 8'd1;
              if (mode_q == MODE_PAGE) st <= ST_HDR;
            end
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        default: if (tx_ready) st <= ST_IDLE;
      endcase
    end
  end

  AST_READY_IN_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (st == ST_DAT)); // R9
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && start) |=> (mode_q == $past(mode_q) && cs_q == $past(cs_q))); // R10
  AST_FIN_WAITS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FIN && !tx_ready) |=> (st == ST_FIN)); // R11
endmodule

// File: rtl/dws_window_seq.sv
`timescale 1ns/1ps
module dws_window_seq #(
  parameter int         CLK_HALF    = 2,
  parameter int         CMD_LEN_W   = 4,
  parameter logic [7:0] ROW_OP      = 8'h75,
  parameter logic [7:0] COL_OP      = 8'h15,
  parameter logic [7:0] RAM_OP      = 8'h5C,
  parameter logic [7:0] PAGE_BASE   = 8'hB0,
  parameter logic [7:0] COLH_BASE   = 8'h10,
  parameter logic [7:0] COLL_BASE   = 8'h00,
  parameter logic [7:0] AMODE_OP    = 8'h20,
  parameter logic [7:0] AMODE_HORIZ = 8'h00,
  parameter logic [7:0] CRANGE_OP   = 8'h21,
  parameter logic [7:0] PRANGE_OP   = 8'h22
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           mode,
  input  logic                 late_dc,
  input  logic [7:0]           col_start,
  input  logic [7:0]           col_end,
  input  logic [7:0]           row_start,
  input  logic [7:0]           row_end,
  input  logic [CMD_LEN_W-1:0] cmd_len,
  input  logic                 s_valid,
  input  logic [7:0]           s_data,
  output logic                 s_ready,
  output logic                 busy,
  output logic                 spi_sclk,
  output logic                 spi_mosi,
  output logic                 spi_cs_n,
  output logic                 spi_dc
);
  logic       tx_ready, tx_valid, tx_dc;
  logic [7:0] tx_byte;

  dws_ctrl #(
    .CMD_LEN_W(CMD_LEN_W), .ROW_OP(ROW_OP), .COL_OP(COL_OP), .RAM_OP(RAM_OP),
    .PAGE_BASE(PAGE_BASE), .COLH_BASE(COLH_BASE), .COLL_BASE(COLL_BASE),
    .AMODE_OP(AMODE_OP), .AMODE_HORIZ(AMODE_HORIZ),
    .CRANGE_OP(CRANGE_OP), .PRANGE_OP(PRANGE_OP)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_i(mode), .late_i(late_dc),
    .col_s(col_start), .col_e(col_end), .row_s(row_start), .row_e(row_end),
    .cmd_len(cmd_len), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_dc(tx_dc),
    .busy(busy), .cs_n(spi_cs_n)
  );

  dws_bit_tx #(.CLK_HALF(CLK_HALF)) u_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(tx_valid), .in_byte(tx_byte),
    .in_dc(tx_dc), .in_ready(tx_ready), .sclk(spi_sclk), .mosi(spi_mosi),
    .dc(spi_dc)
  );

  AST_SELECT_COVERS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready |-> !spi_cs_n); // R2
  AST_STALL_NO_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> (tx_ready && !spi_sclk)); // R9
endmodule

// File: tb/dws_window_seq_tb.sv
`timescale 1ns/1ps
module dws_window_seq_tb;
  localparam logic [7:0] P_ROW = 8'h75, P_COL = 8'h15, P_RAM = 8'h5C;
  localparam logic [7:0] P_PB = 8'hB0, P_CH = 8'h10, P_CL = 8'h00;
  localparam logic [7:0] P_AM = 8'h20, P_AH = 8'h00, P_CR = 8'h21, P_PR = 8'h22;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, late_dc = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] col_start = 0, col_end = 0, row_start = 0, row_end = 0;
  logic [3:0] cmd_len = 0;
  logic s_valid = 1'b0, s_ready, busy, spi_sclk, spi_mosi, spi_cs_n, spi_dc;
  logic [7:0] s_data = 8'h5A;

  always #10 clk = ~clk;

  dws_window_seq #(
    .CLK_HALF(1), .CMD_LEN_W(4), .ROW_OP(P_ROW), .COL_OP(P_COL), .RAM_OP(P_RAM),
    .PAGE_BASE(P_PB), .COLH_BASE(P_CH), .COLL_BASE(P_CL), .AMODE_OP(P_AM),
    .AMODE_HORIZ(P_AH), .CRANGE_OP(P_CR), .PRANGE_OP(P_PR)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .late_dc(late_dc),
    .col_start(col_start), .col_end(col_end), .row_start(row_start),
    .row_end(row_end), .cmd_len(cmd_len), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .busy(busy), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .spi_dc(spi_dc)
  );

  int nchk = 0, nerr = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // wire capture
  logic [7:0] cap_b [0:63];
  logic       cap_d [0:63];
  int ncap = 0, bitk = 0, dc_bad = 0, cs_bad = 0;
  logic [7:0] sh = 0;
  logic dc_first = 0;
  always @(posedge spi_sclk) begin
    if (spi_cs_n) cs_bad++;
    if (bitk == 0) dc_first = spi_dc;
    else if (spi_dc != dc_first) dc_bad++;
    sh = {sh[6:0], spi_mosi};
    bitk++;
    if (bitk == 8) begin
      if (ncap < 64) begin cap_b[ncap] = sh; cap_d[ncap] = dc_first; end
      ncap++;
      bitk = 0;
    end
  end

  // throttled stream source
  logic [7:0] fed [0:63];
  int nfed = 0, gap = 0;
  bit hs = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (hs) begin
        if (nfed < 64) fed[nfed] = s_data;
        nfed++;
        s_data = s_data * 8'd5 + 8'd3;
        if (nfed % 3 == 1) gap = 4;
      end
      if (gap > 0) gap--;
      s_valid = rst_n && (gap == 0);
      #1 hs = s_valid && s_ready;
    end
  end

  logic [7:0] exp_b [0:63];
  logic       exp_d [0:63];
  int ne = 0;
  task automatic push(input logic [7:0] b, input logic d);
    if (ne < 64) begin exp_b[ne] = b; exp_d[ne] = d; end
    ne++;
  endtask

  task automatic run(input logic [1:0] m, input logic [7:0] cl, input int w,
                     input logic [7:0] rl, input int nr, input int clen,
                     input bit late, input bit inject);
    int cols, ndat, di, wait_cyc;
    string tag;
    logic [7:0] ch, rh;
    cols = w + 1;
    ch = cl + 8'(w);
    rh = rl + 8'(nr - 1);
    @(negedge clk); #5;
    ncap = 0; nfed = 0; dc_bad = 0; cs_bad = 0; bitk = 0;
    mode = m; col_start = cl; col_end = ch; row_start = rl; row_end = rh;
    cmd_len = 4'(clen); late_dc = late; start = 1'b1;
    @(negedge clk); #5 start = 1'b0;
    if (inject) begin
      repeat (40) @(negedge clk);
      #5; start = 1'b1; mode = 2'd3; col_start = 8'hEE; row_end = 8'h77;
      @(negedge clk); #5 start = 1'b0;
    end
    wait_cyc = 0;
    while (busy && wait_cyc < 5000) begin @(negedge clk); wait_cyc++; end
    ne = 0; di = 0;
    case (m)
      2'd0: begin
        tag = "R3/R4";
        push(P_ROW, 0); push(rl, 1); push(rh, 1);
        push(P_COL, 0); push(cl, 1); push(ch, 1); push(P_RAM, 0);
        ndat = nr * cols * 2;
        for (int k = 0; k < ndat; k++) push(fed[k], 1);
      end
      2'd1: begin
        tag = "R5";
        ndat = nr * cols;
        for (int p = 0; p < nr; p++) begin
          push(P_PB + rl + 8'(p), 0);
          push(P_CH + {4'h0, cl[7:4]}, 0);
          push(P_CL + {4'h0, cl[3:0]}, 0);
          for (int j = 0; j < cols; j++) begin push(fed[di], 1); di++; end
        end
      end
      2'd2: begin
        tag = "R6";
        push(P_AM, 0); push(P_AH, 0); push(P_CR, 0); push(cl, 0); push(ch, 0);
        push(P_PR, 0); push(rl, 0); push(rh, 0);
        ndat = nr * cols;
        for (int k = 0; k < ndat; k++) push(fed[k], 1);
      end
      default: begin
        tag = "R7";
        ndat = clen + 1;
        push(fed[0], 0);
        for (int k = 1; k <= clen; k++) push(fed[k], !late);
      end
    endcase
    if (inject) tag = "R10";
    chk(!busy, {tag, " R11 busy cleared"}, int'(busy), 0);
    chk(spi_cs_n && bitk == 0, {tag, " R11 select high, no partial byte"}, bitk, 0);
    chk(nfed == ndat, {tag, " R9 stream bytes consumed"}, nfed, ndat);
    chk(ncap == ne, {tag, " byte count on wire"}, ncap, ne);
    for (int k = 0; k < ne && k < ncap && k < 64; k++) begin
      chk(cap_b[k] == exp_b[k], {tag, " R2 byte value"}, cap_b[k], exp_b[k]);
      chk(cap_d[k] == exp_d[k], {tag, " D/C level"}, cap_d[k], exp_d[k]);
    end
    chk(dc_bad == 0, "R8 D/C stable within byte", dc_bad, 0);
    chk(cs_bad == 0, "R2 select low while clocking", cs_bad, 0);
  endtask

  initial begin
    logic [7:0] cls [0:2];
    cls[0] = 8'd0; cls[1] = 8'd44; cls[2] = 8'd167;
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R1 cs_n in reset", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R1 sclk in reset", spi_sclk, 0);
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    chk(s_ready == 1'b0, "R1 s_ready in reset", s_ready, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(spi_cs_n && !busy && !s_ready, "R1 idle after reset", busy, 0);
    for (int m = 0; m < 3; m++)
      for (int c = 0; c < 3; c++)
        for (int w = 0; w < 3; w++)
          for (int r = 0; r < 2; r++)
            for (int nr = 1; nr <= 3; nr++)
              run(2'(m), cls[c], w, r ? 8'd5 : 8'd0, nr, 0, 1'b0, 1'b0);
    for (int l = 0; l < 5; l++)
      for (int lt = 0; lt < 2; lt++)
        run(2'd3, 8'd0, 0, 8'd0, 1, l, lt[0], 1'b0);
    run(2'd0, 8'd44, 2, 8'd5, 3, 0, 1'b0, 1'b1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule